// File: doc/BRIEF.md
# Tag Store with Built-in Match Comparator

This block keeps one tag word per cache line together with a validity flag. In a compare cycle, it checks a presented tag against the word held at the addressed line and reports a hit. A controller uses it in two ways. It writes the tag of a line when that line is filled. On a lookup, it presents the address and the tag, and one clock later it reads a single active-low match line. Ordinary reads return the stored word, so the tag of a line can be recovered before the line is evicted.

A chip select, a write enable and an output enable classify each clocked cycle as one of four kinds: write, read, compare or idle. The shared data pin is split into an input bus, an output bus and a drive enable. The match line is modelled as an open-drain pin with a separate drive enable, so several instances can be wired together. A clear request invalidates every line. The clear walks the valid-flag store one word per clock and raises a busy flag while it runs. A synchronous reset starts the same walk. The default depth is 1K lines and can be set through `ADDR_W`: 13 gives 8K lines of 8 bits.

Top module: `tag_match_ram`

## Requirements
- R1: A write cycle (cs=1, we=1) stores dq_in at addr and marks that line valid. A later read of the line returns the written word.
- R2: A read cycle (cs=1, we=0, oe=1) gives dq_drive=1 and dq_out equal to the stored word in the next cycle. In any other cycle, dq_drive=0 and dq_out=0.
- R3: A compare cycle (cs=1, we=0, oe=0) gives match_drv=1 in the next cycle. In that cycle, match_n=0 if the line is valid and its stored word equals dq_in, and match_n=1 otherwise.
- R4: After any cycle that is not a compare, match_drv=0 and match_n=1 (the line is released).
- R5: While rst is high, busy is 1. After rst falls, busy stays 1 for exactly 2^(ADDR_W-VSEL_W) cycles, and then no line is valid.
- R6: A tag_clear pulse sets busy in the next cycle and holds it for 2^(ADDR_W-VSEL_W) cycles. A second pulse restarts the count. Afterwards every line is invalid, but stored words are unchanged and still readable.
- R7: An access presented while busy=1, or in the same cycle as tag_clear, is ignored. It writes nothing, and both outputs stay released.
- R8: When cs=1 and we=1, the cycle is a write whatever the value of oe.
- R9: With cs=0, nothing is written, and both outputs are released in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts the invalidation walk |
| tag_clear | input | 1 | Request to invalidate every line |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | Write enable, active high |
| oe | input | 1 | Output enable, active high |
| addr | input | ADDR_W | Line address |
| dq_in | input | TAG_W | Tag to write or to compare |
| dq_out | output | TAG_W | Read data, zero when not driven |
| dq_drive | output | 1 | Output drive enable for the data pins |
| match_n | output | 1 | Match result, active low |
| match_drv | output | 1 | Drive enable of the open-drain match line |
| busy | output | 1 | Invalidation walk in progress |

## Verification
Compare cycles are exercised in four ways:
- Against lines that were just written, with the exact tag, which separates a hit from a miss.
- Against the same lines with one tag bit flipped, which catches a comparator that looks at too few bits.
- Against never-written lines and lines on either side of a valid-word boundary, which catches valid-bit selection errors.
- Against written lines after a clear, where the stored word still equals the presented tag, which tells validity apart from data equality.

Writes are also presented with output enable high, with chip select low, in the same cycle as a clear and during the walk. Each of these shows whether the cycle classification and the ignore rule are honoured. Reads after a clear confirm that invalidation leaves the stored words alone.

// File: rtl/tagram_pkg.sv
package tagram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_CMP   = 2'd3
  } op_e;
endpackage

// File: rtl/tagram_ctrl.sv
module tagram_ctrl
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int VSEL_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tag_clear,
  input  logic                     cs,
  input  logic                     we,
  input  logic                     oe,
  output op_e                      op,
  output logic                     busy,
  output logic                     sweep_en,
  output logic [ADDR_W-VSEL_W-1:0] sweep_idx
);
  localparam int WIDX_W = ADDR_W - VSEL_W;
  localparam logic [WIDX_W-1:0] LAST = '1;

  logic [WIDX_W-1:0] cnt;

  // invalidation walk: one valid word per clock
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (tag_clear) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign sweep_en  = busy;
  assign sweep_idx = cnt;

  // cycle classification; write wins over output enable
  always_comb begin
    if (rst || busy || tag_clear || !cs) op = OP_IDLE;
    else if (we)                         op = OP_WRITE;
    else if (oe)                         op = OP_READ;
    else                                 op = OP_CMP;
  end

  // R6: a clear request always leads to a busy walk
  a_r6_clear_sets_busy: assert property (@(posedge clk) disable iff (rst)
    tag_clear |=> busy);
  // R7: no access is issued while the walk runs
  a_r7_idle_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (op == OP_IDLE));
endmodule

// File: rtl/tagram_store.sv
module tagram_store #(
  parameter int ADDR_W = 10,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  wdata,
  output logic [TAG_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] mem [DEPTH];

  // single-port, read-first: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/tagram_valid.sv
module tagram_valid #(
  parameter int ADDR_W = 10,
  parameter int VSEL_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic                     set_en,
  input  logic                     clr_en,
  input  logic [ADDR_W-VSEL_W-1:0] clr_idx,
  output logic                     entry_valid
);
  localparam int VW     = 1 << VSEL_W;
  localparam int WIDX_W = ADDR_W - VSEL_W;
  localparam int NWORDS = 1 << WIDX_W;

  logic [VW-1:0]     vmem [NWORDS];
  logic [WIDX_W-1:0] widx;
  logic [VSEL_W-1:0] bsel;
  logic [VW-1:0]     bit_we;
  logic              bit_wd;
  logic [VW-1:0]     rword;
  logic [VSEL_W-1:0] bsel_q;

  assign bsel   = acc_addr[VSEL_W-1:0];
  assign widx   = clr_en ? clr_idx : acc_addr[ADDR_W-1:VSEL_W];
  assign bit_wd = ~clr_en;

  // per-bit write enables: whole word on clear, one bit on set
  generate
    for (genvar b = 0; b < VW; b++) begin : g_bwe
      assign bit_we[b] = clr_en | (set_en & (bsel == VSEL_W'(b)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int b = 0; b < VW; b++) begin
      if (bit_we[b]) vmem[widx][b] <= bit_wd;
    end
    rword  <= vmem[acc_addr[ADDR_W-1:VSEL_W]];
    bsel_q <= bsel;
  end

  assign entry_valid = rword[bsel_q];

  // R7: setting a flag and the walk never share a cycle
  a_r7_no_set_in_walk: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> !set_en);
endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp
  import tagram_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [TAG_W-1:0] stored,
  input  logic             entry_valid,
  output logic [TAG_W-1:0] dq_out,
  output logic             dq_drive,
  output logic             match_n,
  output logic             match_drv
);
  op_e              op_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) op_q <= OP_IDLE;
    else     op_q <= op;
    tag_q <= tag_in;
  end

  // all outputs come from registers only, no path from the inputs
  assign match_drv = (op_q == OP_CMP);
  assign match_n   = !(match_drv && entry_valid && (stored == tag_q));
  assign dq_drive  = (op_q == OP_READ);
  assign dq_out    = dq_drive ? stored : '0;
endmodule

// File: rtl/tag_match_ram.sv
module tag_match_ram
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TAG_W  = 8,
  parameter int VSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tag_clear,
  input  logic              cs,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  dq_in,
  output logic [TAG_W-1:0]  dq_out,
  output logic              dq_drive,
  output logic              match_n,
  output logic              match_drv,
  output logic              busy
);
  localparam int WIDX_W = ADDR_W - VSEL_W;

  op_e               op;
  logic              sweep_en;
  logic [WIDX_W-1:0] sweep_idx;
  logic [TAG_W-1:0]  stored;
  logic              entry_valid;
  logic              wr_cycle;

  assign wr_cycle = (op == OP_WRITE);

  tagram_ctrl #(.ADDR_W(ADDR_W), .VSEL_W(VSEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .tag_clear(tag_clear), .cs(cs), .we(we), .oe(oe),
    .op(op), .busy(busy), .sweep_en(sweep_en), .sweep_idx(sweep_idx)
  );

  tagram_store #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .wr_en(wr_cycle), .addr(addr), .wdata(dq_in), .rdata(stored)
  );

  tagram_valid #(.ADDR_W(ADDR_W), .VSEL_W(VSEL_W)) u_valid (
    .clk(clk), .rst(rst), .acc_addr(addr), .set_en(wr_cycle),
    .clr_en(sweep_en), .clr_idx(sweep_idx), .entry_valid(entry_valid)
  );

  tagram_cmp #(.TAG_W(TAG_W)) u_cmp (
    .clk(clk), .rst(rst), .op(op), .tag_in(dq_in), .stored(stored),
    .entry_valid(entry_valid), .dq_out(dq_out), .dq_drive(dq_drive),
    .match_n(match_n), .match_drv(match_drv)
  );

  logic acc_ok;
  assign acc_ok = !busy && !tag_clear;

  a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && cs && !we && oe) |=> (dq_drive && !match_drv));
  a_r3_cmp_drives: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && cs && !we && !oe) |=> (match_drv && !dq_drive));
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && cs && we) |=> (!dq_drive && !match_drv && match_n));
  a_r9_deselect_releases: assert property (@(posedge clk) disable iff (rst)
    !cs |=> (!dq_drive && !match_drv && match_n));
  a_r7_walk_releases: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!dq_drive && !match_drv));
endmodule

// File: tb/tag_match_ram_tb.sv
module tag_match_ram_tb;
  localparam int ADDR_W = 10;
  localparam int TAG_W  = 8;
  localparam int VSEL_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NW     = 1 << (ADDR_W - VSEL_W);

  logic clk = 1'b0;
  logic rst, tag_clear, cs, we, oe;
  logic [ADDR_W-1:0] addr;
  logic [TAG_W-1:0]  dq_in;
  logic [TAG_W-1:0]  dq_out;
  logic dq_drive, match_n, match_drv, busy;

  always #5 clk = ~clk;

  tag_match_ram #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .VSEL_W(VSEL_W)) u_dut (
    .clk(clk), .rst(rst), .tag_clear(tag_clear), .cs(cs), .we(we), .oe(oe),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive),
    .match_n(match_n), .match_drv(match_drv), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int  tag_m [DEPTH];
  bit  known_m [DEPTH];
  bit  valid_m [DEPTH];
  int  rem = 0;
  bit  armed = 0;
  bit  e_rd, e_cm, e_mn, e_busy, e_known;
  int  e_data;
  string req = "R5";

  always @(posedge clk) begin
    e_rd = 0; e_cm = 0; e_mn = 1; e_known = 0; e_data = 0;
    if (rst) begin
      rem = NW; req = "R5";
      for (int i = 0; i < DEPTH; i++) valid_m[i] = 0;
    end else if (tag_clear) begin
      rem = NW; req = "R6";
      for (int i = 0; i < DEPTH; i++) valid_m[i] = 0;
    end else if (rem > 0) begin
      rem--; req = "R7";
    end else if (cs) begin
      if (we) begin
        tag_m[addr] = int'(dq_in); known_m[addr] = 1; valid_m[addr] = 1;
        req = oe ? "R8" : "R4";
      end else if (oe) begin
        e_rd = 1; e_known = known_m[addr]; e_data = tag_m[addr];
        req = e_known ? "R1" : "R2";
      end else begin
        e_cm = 1;
        e_mn = !(valid_m[addr] && known_m[addr] && tag_m[addr] == int'(dq_in));
        req = "R3";
      end
    end else begin
      req = "R9";
    end
    e_busy = (rem > 0);
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk(req, "busy", int'(busy), int'(e_busy));
      chk(req, "dq_drive", int'(dq_drive), int'(e_rd));
      chk(req, "match_drv", int'(match_drv), int'(e_cm));
      chk(req, "match_n", int'(match_n), int'(e_mn));
      if (!e_rd) chk(req, "dq_out idle", int'(dq_out), 0);
      else if (e_known) chk(req, "dq_out", int'(dq_out), e_data);
    end
  end

  task automatic step(bit c, bit w, bit o, int a, int d);
    @(negedge clk);
    cs = c; we = w; oe = o; addr = ADDR_W'(a); dq_in = TAG_W'(d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    rst = 1; tag_clear = 0; cs = 0; we = 0; oe = 0; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    chk("R5", "busy in reset", int'(busy), 1);
    rst = 0;
    idle(NW + 2);
    chk("R5", "busy after walk", int'(busy), 0);

    step(1, 0, 0, 5, 0);          // unwritten line: miss (R5)
    step(1, 1, 0, 5, 8'h5A);      // R1 write
    step(1, 0, 0, 5, 8'h5A);      // R3 hit
    @(negedge clk);
    chk("R3", "hit", int'(match_n), 0);
    step(1, 0, 0, 5, 8'h5B);      // R3 miss
    step(1, 0, 1, 5, 0);          // R2 read
    @(negedge clk);
    chk("R1", "readback", int'(dq_out), 8'h5A);

    step(1, 1, 1, 9, 8'hC3);      // R8 write with oe high
    step(1, 0, 1, 9, 0);
    @(negedge clk);
    chk("R8", "write with oe", int'(dq_out), 8'hC3);

    for (int i = 0; i < 32; i++) step(1, 1, 0, (i * 33 + 100) % DEPTH, i * 7 + 1);
    for (int i = 0; i < 32; i++) begin
      step(1, 0, 0, (i * 33 + 100) % DEPTH, i * 7 + 1);
      step(1, 0, 0, (i * 33 + 100) % DEPTH, (i * 7 + 1) ^ (1 << (i % TAG_W)));
    end

    step(1, 1, 0, DEPTH - 1, 8'hEE);
    step(1, 1, 0, 0, 8'h00);
    step(1, 1, 0, 15, 8'h77);
    step(1, 0, 0, 16, 8'h77);     // neighbour across valid word: miss
    step(1, 0, 0, 15, 8'h77);
    step(1, 0, 0, DEPTH - 1, 8'hEE);
    step(1, 0, 0, 0, 8'h00);

    step(0, 1, 0, 5, 8'h00);      // R9 deselected write
    step(1, 0, 1, 5, 0);
    @(negedge clk);
    chk("R9", "deselect no write", int'(dq_out), 8'h5A);

    // clear with a write in the same cycle (R7)
    @(negedge clk);
    cs = 1; we = 1; oe = 0; addr = 5; dq_in = 8'h11; tag_clear = 1;
    @(negedge clk);
    tag_clear = 0;
    chk("R6", "busy after clear", int'(busy), 1);
    step(1, 1, 0, 5, 8'h22);      // ignored in walk
    step(1, 0, 0, 5, 8'h5A);
    idle(10);
    @(negedge clk); tag_clear = 1; cs = 0;   // restart
    @(negedge clk); tag_clear = 0;
    idle(NW - 2);
    chk("R6", "busy near end", int'(busy), 1);
    idle(2);
    chk("R6", "busy done", int'(busy), 0);
    step(1, 0, 0, 5, 8'h5A);      // stored equal but invalid: miss
    @(negedge clk);
    chk("R6", "invalid after clear", int'(match_n), 1);
    step(1, 0, 1, 5, 0);
    @(negedge clk);
    chk("R6", "tag kept", int'(dq_out), 8'h5A);
    step(1, 0, 0, 9, 8'hC3);
    step(1, 1, 0, 9, 8'hC3);
    step(1, 0, 0, 9, 8'hC3);
    @(negedge clk);
    chk("R1", "valid again", int'(match_n), 0);
    idle(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule